// File: doc/BRIEF.md
# Privilege-Filtered Address Match Trigger

This block watches one debug trigger slot. On every cycle it compares the slot's compare address with the current instruction fetch PC and with the current load or store address. It then decides whether the trigger fires. A hit is allowed only when several conditions hold together: the slot's type code, the current privilege level, the virtualization state, a legal access-size code and an optional context comparison. Matching is exact address equality. Range compares, chaining and data-value compares are not provided.

The result is registered. `hit_o` is a single-cycle pulse in the cycle after the qualifying inputs. `trap_addr_o` carries the address that caused the hit and keeps that value until the next hit. A core would instantiate one copy per trigger slot and route the pulse to its breakpoint or exception logic.

Top module: `addr_match_trigger`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it goes high, `hit_o` is 0 and `trap_addr_o` is 0.
- R2: When `trig_en` is 0 in a cycle, no hit is produced from that cycle's inputs.
- R3: A slot whose type field `ctl_word[31:28]` equals 2 never hits while `virt_on` is 1.
- R4: For type 2 with `virt_on` 0, the slot is enabled only when control bit 3+`priv_lvl` is set. The privilege codes are U=0, S=1, M=3.
- R5: For type 6, the enabling control bit is 23+`priv_lvl` when `virt_on` is 1 and 3+`priv_lvl` when it is 0.
- R6: A type field other than 2 or 6 never produces a hit.
- R7: An execute hit needs control bit 2, `fetch_valid` and `fetch_pc == cmp_addr`. One cycle later `hit_o` is 1 and `trap_addr_o` equals that PC.
- R8: An access hit needs `acc_valid`, `acc_addr == cmp_addr` and the direction bit for the access: bit 0 for a load (`acc_store`=0) or bit 1 for a store. `trap_addr_o` then takes the access address. When an execute hit and an access hit occur in the same cycle, the execute hit wins.
- R9: The size field is `ctl_word[19:16]`. Codes 4 and 6..15 are illegal and block every hit. Code 0 means any size. Codes 1, 2, 3 and 5 require an access of log2 size (`acc_size`) 0, 1, 2 and 3 respectively. Execute hits do not depend on the size code, as long as the code is legal.
- R10: When `ctx_word[0]` is 1, a hit also requires `ctx_word[CTX_W:1] == mctx`. When `ctx_word[0]` is 0, the context value is ignored.
- R11: In any cycle without a hit, `trap_addr_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_en | input | 1 | Qualifies the trigger this cycle |
| ctl_word | input | XLEN | Control word: type, enables, size, direction |
| cmp_addr | input | XLEN | Compare address |
| priv_lvl | input | 2 | Current privilege (U=0, S=1, M=3) |
| virt_on | input | 1 | Virtualization enabled |
| fetch_valid | input | 1 | Instruction fetch present |
| fetch_pc | input | XLEN | Fetch PC |
| acc_valid | input | 1 | Load/store access present |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_size | input | 2 | Log2 of access bytes |
| acc_addr | input | XLEN | Access address |
| ctx_word | input | CTX_W+1 | Bit 0 context select, upper bits stored context |
| mctx | input | CTX_W | Machine context value |
| hit_o | output | 1 | Registered hit pulse |
| trap_addr_o | output | XLEN | Address of the last hit |

## Verification
A wrong enable-bit index would show up on `hit_o` as a missing or extra pulse for one specific privilege and virtualization pairing, one cycle after the stimulus. The bench therefore sweeps every type, privilege, virtualization and single-bit enable combination. A corrupted trap register would show up as a wrong `trap_addr_o`, either on the same cycle as the hit or during the idle cycles that follow it. The bench compares the trap value after every stimulus and checks every size code against every access size.

// File: rtl/amt_pkg.sv
package amt_pkg;
    localparam int TYPE_LSB   = 28;
    localparam int SIZE_LSB   = 16;
    localparam int BIT_LOAD   = 0;
    localparam int BIT_STORE  = 1;
    localparam int BIT_EXEC   = 2;
    localparam int NV_BASE    = 3;
    localparam int VIRT_BASE  = 23;
    localparam logic [3:0] TYPE_LEGACY = 4'd2;
    localparam logic [3:0] TYPE_EXT    = 4'd6;

    typedef enum logic [1:0] {PRIV_U = 2'd0, PRIV_S = 2'd1, PRIV_R = 2'd2, PRIV_M = 2'd3} priv_e;

    function automatic logic size_legal(input logic [3:0] code);
        return (code <= 4'd3) || (code == 4'd5);
    endfunction

    function automatic logic size_fits(input logic [3:0] code, input logic [1:0] lg);
        case (code)
            4'd0:    return 1'b1;
            4'd1:    return lg == 2'd0;
            4'd2:    return lg == 2'd1;
            4'd3:    return lg == 2'd2;
            4'd5:    return lg == 2'd3;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/amt_priv_sel.sv
module amt_priv_sel
    import amt_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] ctl_word,
    input  logic [1:0]      priv_lvl,
    input  logic            virt_on,
    output logic            priv_ok
);
    logic [3:0] ttype;
    logic [4:0] idx;
    logic       is_leg, is_ext;

    always_comb begin
        ttype  = ctl_word[TYPE_LSB+3:TYPE_LSB];
        is_leg = (ttype == TYPE_LEGACY);
        is_ext = (ttype == TYPE_EXT);
        idx    = (is_ext && virt_on) ? 5'(VIRT_BASE) : 5'(NV_BASE);
        idx    = idx + {3'b000, priv_lvl};
        priv_ok = 1'b0;
        if (is_ext)
            priv_ok = ctl_word[idx];
        else if (is_leg && !virt_on)
            priv_ok = ctl_word[idx];
    end

    // R3: legacy type never enabled with virtualization on
    always_comb begin
        p_leg_no_virt_r3: assert (!(is_leg && virt_on && priv_ok));
    end
endmodule

// File: rtl/amt_addr_cmp.sv
module amt_addr_cmp
    import amt_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] ctl_word,
    input  logic [XLEN-1:0] cmp_addr,
    input  logic            fetch_valid,
    input  logic [XLEN-1:0] fetch_pc,
    input  logic            acc_valid,
    input  logic            acc_store,
    input  logic [1:0]      acc_size,
    input  logic [XLEN-1:0] acc_addr,
    output logic            exec_m,
    output logic            acc_m
);
    logic [3:0] scode;
    logic       legal, dir_ok;

    always_comb begin
        scode  = ctl_word[SIZE_LSB+3:SIZE_LSB];
        legal  = size_legal(scode);
        dir_ok = acc_store ? ctl_word[BIT_STORE] : ctl_word[BIT_LOAD];
        exec_m = legal && ctl_word[BIT_EXEC] && fetch_valid && (fetch_pc == cmp_addr);
        acc_m  = legal && acc_valid && dir_ok && (acc_addr == cmp_addr)
                 && size_fits(scode, acc_size);
    end

    // R9: illegal size code blocks every match
    always_comb begin
        p_bad_size_r9: assert (size_legal(scode) || !(exec_m || acc_m));
    end
endmodule

// File: rtl/amt_ctx_cmp.sv
module amt_ctx_cmp #(
    parameter int CTX_W = 8
) (
    input  logic [CTX_W:0]   ctx_word,
    input  logic [CTX_W-1:0] mctx,
    output logic             ctx_ok
);
    always_comb begin
        ctx_ok = !ctx_word[0] || (ctx_word[CTX_W:1] == mctx);
    end

    // R10: selected context must equal machine context
    always_comb begin
        p_ctx_eq_r10: assert (!(ctx_word[0] && ctx_ok) || (ctx_word[CTX_W:1] == mctx));
    end
endmodule

// File: rtl/addr_match_trigger.sv
module addr_match_trigger
    import amt_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CTX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_en,
    input  logic [XLEN-1:0]  ctl_word,
    input  logic [XLEN-1:0]  cmp_addr,
    input  logic [1:0]       priv_lvl,
    input  logic             virt_on,
    input  logic             fetch_valid,
    input  logic [XLEN-1:0]  fetch_pc,
    input  logic             acc_valid,
    input  logic             acc_store,
    input  logic [1:0]       acc_size,
    input  logic [XLEN-1:0]  acc_addr,
    input  logic [CTX_W:0]   ctx_word,
    input  logic [CTX_W-1:0] mctx,
    output logic             hit_o,
    output logic [XLEN-1:0]  trap_addr_o
);
    typedef struct packed {
        logic            hit;
        logic [XLEN-1:0] trap;
    } state_t;

    state_t st_d, st_q;
    logic   priv_ok, exec_m, acc_m, ctx_ok, fire;

    amt_priv_sel #(.XLEN(XLEN)) u_priv (
        .ctl_word(ctl_word), .priv_lvl(priv_lvl), .virt_on(virt_on), .priv_ok(priv_ok)
    );

    amt_addr_cmp #(.XLEN(XLEN)) u_cmp (
        .ctl_word(ctl_word), .cmp_addr(cmp_addr),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .acc_valid(acc_valid), .acc_store(acc_store), .acc_size(acc_size),
        .acc_addr(acc_addr), .exec_m(exec_m), .acc_m(acc_m)
    );

    amt_ctx_cmp #(.CTX_W(CTX_W)) u_ctx (
        .ctx_word(ctx_word), .mctx(mctx), .ctx_ok(ctx_ok)
    );

    always_comb begin
        st_d     = st_q;
        fire     = trig_en && priv_ok && ctx_ok && (exec_m || acc_m);
        st_d.hit = fire;
        if (fire)
            st_d.trap = exec_m ? fetch_pc : acc_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_o       = st_q.hit;
    assign trap_addr_o = st_q.trap;

    // R2: a hit needs the enable in the previous cycle
    p_en_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(trig_en));
    // R11: trap address holds between hits
    p_trap_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> $stable(trap_addr_o));
    // R7: execute hit reports the fetch PC
    p_exec_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en && priv_ok && ctx_ok && exec_m) |=> (hit_o && trap_addr_o == $past(fetch_pc)));
    // R6: unknown types never hit
    p_bad_type_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_word[TYPE_LSB+3:TYPE_LSB] != TYPE_LEGACY && ctl_word[TYPE_LSB+3:TYPE_LSB] != TYPE_EXT)
        |=> !hit_o);
endmodule

// File: tb/tb_addr_match_trigger.sv
module tb_addr_match_trigger;
    localparam int XLEN = 32;
    localparam int CW   = 8;

    logic            clk = 0, rst_n = 0;
    logic            trig_en = 0, virt_on = 0, fetch_valid = 0, acc_valid = 0, acc_store = 0;
    logic [XLEN-1:0] ctl_word = '0, cmp_addr = '0, fetch_pc = '0, acc_addr = '0;
    logic [1:0]      priv_lvl = 0, acc_size = 0;
    logic [CW:0]     ctx_word = '0;
    logic [CW-1:0]   mctx = '0;
    logic            hit_o;
    logic [XLEN-1:0] trap_addr_o;

    int checks = 0, errors = 0;
    logic [XLEN-1:0] exp_trap = '0;

    always #5 clk = ~clk;

    addr_match_trigger #(.XLEN(XLEN), .CTX_W(CW)) dut (.*);

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at negedge, sample one edge later, then idle one cycle to check hold
    task automatic step(input string req, input logic exp_hit, input logic [XLEN-1:0] hit_addr);
        @(posedge clk); #1;
        if (exp_hit) exp_trap = hit_addr;
        chk(req, {31'b0, hit_o}, {31'b0, exp_hit});
        chk(req, trap_addr_o, exp_trap);
        @(negedge clk);
        fetch_valid = 0; acc_valid = 0;
        @(posedge clk); #1;
        chk("R11", {31'b0, hit_o}, 32'd0);
        chk("R11", trap_addr_o, exp_trap);
        @(negedge clk);
    endtask

    function automatic logic priv_model(input int ty, input int v, input int p, input int b);
        if (ty == 2) return (v == 0) && (b == 3 + p);
        if (ty == 6) return b == ((v != 0) ? 23 : 3) + p;
        return 1'b0;
    endfunction

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2;
        chk("R1", {31'b0, hit_o}, 32'd0);
        chk("R1", trap_addr_o, 32'd0);
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(posedge clk); #1;
        chk("R1", {31'b0, hit_o}, 32'd0);
        chk("R1", trap_addr_o, 32'd0);
        @(negedge clk);

        cmp_addr = 32'h8000_1000;
        trig_en  = 1;
        // R3 R4 R5 R6 R7: full privilege sweep, execute match
        foreach (ctl_word[i]) ;
        for (int ty = 1; ty <= 7; ty++) begin
            for (int v = 0; v < 2; v++) begin
                for (int p = 0; p < 4; p++) begin
                    for (int b = 2; b <= 27; b++) begin
                        if (b > 7 && b < 22) continue;
                        ctl_word = (32'(ty) << 28) | 32'h4 | (32'd1 << b);
                        virt_on = v[0]; priv_lvl = p[1:0];
                        fetch_valid = 1; fetch_pc = cmp_addr ^ 32'(p * 8 + v);
                        fetch_pc = cmp_addr;
                        step((ty == 2) ? (v ? "R3" : "R4") : ((ty == 6) ? "R5" : "R6"),
                             priv_model(ty, v, p, b), fetch_pc);
                    end
                end
            end
        end

        // R7: PC mismatch and exec bit clear
        virt_on = 0; priv_lvl = 3;
        ctl_word = (32'd2 << 28) | (32'd1 << 6) | 32'h4;
        fetch_valid = 1; fetch_pc = cmp_addr + 4;
        step("R7", 0, 0);
        ctl_word = (32'd2 << 28) | (32'd1 << 6);
        fetch_valid = 1; fetch_pc = cmp_addr;
        step("R7", 0, 0);

        // R2: enable low
        ctl_word = (32'd2 << 28) | (32'd1 << 6) | 32'h4;
        trig_en = 0; fetch_valid = 1; fetch_pc = cmp_addr;
        step("R2", 0, 0);
        trig_en = 1;

        // R8 R9: direction x size code x access size
        for (int st = 0; st < 2; st++) begin
            for (int dirb = 0; dirb < 4; dirb++) begin
                for (int sc = 0; sc < 16; sc++) begin
                    for (int sz = 0; sz < 4; sz++) begin
                        logic dir_ok, sz_ok;
                        ctl_word = (32'd6 << 28) | (32'd1 << 6) | (32'(sc) << 16) | 32'(dirb);
                        acc_valid = 1; acc_store = st[0]; acc_size = sz[1:0];
                        acc_addr = cmp_addr;
                        dir_ok = st ? dirb[1] : dirb[0];
                        case (sc)
                            0: sz_ok = 1;
                            1: sz_ok = (sz == 0);
                            2: sz_ok = (sz == 1);
                            3: sz_ok = (sz == 2);
                            5: sz_ok = (sz == 3);
                            default: sz_ok = 0;
                        endcase
                        step((sc == 4 || sc > 5) ? "R9" : "R8", dir_ok && sz_ok, acc_addr);
                    end
                end
            end
        end

        // R9: illegal size blocks execute too
        ctl_word = (32'd6 << 28) | (32'd1 << 6) | (32'd7 << 16) | 32'h4;
        fetch_valid = 1; fetch_pc = cmp_addr;
        step("R9", 0, 0);
        // R8: address mismatch
        ctl_word = (32'd6 << 28) | (32'd1 << 6) | 32'h3;
        acc_valid = 1; acc_store = 0; acc_size = 2; acc_addr = cmp_addr + 1;
        step("R8", 0, 0);
        // R8: execute wins over access
        ctl_word = (32'd6 << 28) | (32'd1 << 6) | 32'h7;
        fetch_valid = 1; fetch_pc = cmp_addr; acc_valid = 1; acc_addr = cmp_addr;
        step("R8", 1, cmp_addr);

        // R10: context select
        for (int sel = 0; sel < 2; sel++) begin
            for (int m = 0; m < 2; m++) begin
                ctl_word = (32'd2 << 28) | (32'd1 << 6) | 32'h4;
                mctx = 8'h5A;
                ctx_word = {(m ? 8'h5A : 8'hA5), sel[0]};
                fetch_valid = 1; fetch_pc = cmp_addr;
                step("R10", (sel == 0) || (m == 1), cmp_addr);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule